// File: doc/BRIEF.md
# Energy Accumulator with Programmable Time Base

This block integrates a stream of power readings into an energy count. A reload counter divides the system clock into integration ticks. On every tick the most recent power code is scaled by a host-selected time step and added into a wide accumulator. The upstream measurement path delivers a 16-bit power code with a one-cycle valid strobe. Samples may arrive faster or slower than the ticks, and a tick with no fresh sample reuses the last one received.

The accumulator wraps when it overflows and raises a sticky rollover flag, which only the host can clear. The host never reads the live accumulator. A snapshot request copies the count and the flag into a hold register in a single cycle, so the value read back is always consistent. The host can zero the accumulator after offloading a snapshot. The tick period and the step scale together set the trade-off between resolution and how often the count wraps.

Top module: `energy_integrator`

## Requirements
- R1: `tick_out` is high for exactly one cycle in every `reload_val + 1` cycles. A reload value of zero gives a tick on every cycle.
- R2: `reload_val` is sampled only in a tick cycle and sets the length of the next period. A change made mid-period does not shorten or lengthen the period already running. After reset the first period lasts `RST_RELOAD + 1` cycles.
- R3: On a tick that is not cleared, the accumulator grows by the power value shifted left by `step_shift` (0 to 3), which is sampled in that same cycle.
- R4: The power value used on a tick is `pwr_code` if `pwr_valid` is high in that cycle. Otherwise it is the last code accepted with `pwr_valid`, or zero if none has been accepted since reset.
- R5: The accumulator counts modulo 2^ACC_W. An add that carries out of the top bit sets `roll_flag` on the next cycle.
- R6: `roll_flag` stays set until a cycle with `clr_roll` high and no carry. When a carry and `clr_roll` fall in the same cycle, the flag ends up set.
- R7: `clr_acc` zeroes the accumulator on the next cycle. A tick in the same cycle adds nothing and cannot set `roll_flag`. `clr_acc` leaves `roll_flag` unchanged.
- R8: `snap_req` copies the accumulator and `roll_flag` as they stand in that cycle, before that cycle's update, to `snap_energy` and `snap_roll`. The snapshot outputs hold until the next request.
- R9: Reset zeroes the accumulator, the held power value, `roll_flag` and both snapshot outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_code | input | PWR_W (16) | Power code from the measurement path |
| pwr_valid | input | 1 | Strobe marking `pwr_code` as a new sample |
| reload_val | input | DIV_W (16) | Tick period minus one, in clock cycles |
| step_shift | input | SHIFT_W (2) | Left shift applied to the power value per tick |
| clr_acc | input | 1 | Zero the accumulator |
| clr_roll | input | 1 | Clear the rollover flag |
| snap_req | input | 1 | Capture accumulator and flag into the snapshot |
| snap_energy | output | ACC_W (32) | Captured accumulator value |
| snap_roll | output | 1 | Captured rollover flag |
| roll_flag | output | 1 | Live sticky rollover flag |
| tick_out | output | 1 | Integration tick pulse |

## Verification
The bench targets four kinds of event:
- A reload write in the middle of a period. A design that loads it at once would put ticks in the wrong place.
- A tick with no fresh sample. A design that adds zero, or adds the stale input bus, would drift away from the model.
- A clear that lands exactly on a tick cycle. A design that lets the add through would leave a non-zero residue in the next snapshot.
- A carry that coincides with `clr_roll`. A design that gives the clear priority would lose the overflow.

Snapshots taken on tick cycles also expose a design that captures the post-update value instead of the current one.

// File: rtl/eacc_pkg.sv
package eacc_pkg;

  localparam int unsigned PWR_W_DEF   = 16;
  localparam int unsigned ACC_W_DEF   = 32;
  localparam int unsigned DIV_W_DEF   = 16;
  localparam int unsigned SHIFT_W_DEF = 2;

  // What the accumulator does in a given cycle; a clear outranks a tick.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_ADD   = 2'd2
  } acc_action_e;

  function automatic acc_action_e pick_action(input logic clr, input logic tick);
    if (clr)       return ACT_CLEAR;
    else if (tick) return ACT_ADD;
    else           return ACT_HOLD;
  endfunction

endpackage

// File: rtl/eacc_timebase.sv
module eacc_timebase #(
  parameter int unsigned DIV_W      = eacc_pkg::DIV_W_DEF,
  parameter int unsigned RST_RELOAD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload_in,
  output logic             tick
);

  localparam logic [DIV_W-1:0] RST_CNT = DIV_W'(RST_RELOAD);

  logic [DIV_W-1:0] cnt_q;

  // Tick when the down-counter reaches zero; the reload is sampled only here.
  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= RST_CNT;
    else if (tick) cnt_q <= reload_in;
    else           cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/eacc_sample_scale.sv
module eacc_sample_scale #(
  parameter int unsigned PWR_W   = eacc_pkg::PWR_W_DEF,
  parameter int unsigned ACC_W   = eacc_pkg::ACC_W_DEF,
  parameter int unsigned SHIFT_W = eacc_pkg::SHIFT_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PWR_W-1:0]   pwr_code,
  input  logic               pwr_valid,
  input  logic [SHIFT_W-1:0] step_shift,
  output logic [PWR_W-1:0]   pwr_used,
  output logic [ACC_W-1:0]   step_inc
);

  localparam int unsigned MAX_SHIFT = (1 << SHIFT_W) - 1;

  // Parameter guard: the largest scaled step must fit the accumulator.
  if (ACC_W < PWR_W + MAX_SHIFT) begin : g_bad_width
    initial $error("ACC_W too narrow for PWR_W and SHIFT_W");
  end

  logic [PWR_W-1:0] hold_q;

  // A fresh sample wins over the held one.
  function automatic logic [PWR_W-1:0] choose_power(input logic vld,
                                                    input logic [PWR_W-1:0] fresh,
                                                    input logic [PWR_W-1:0] held);
    return vld ? fresh : held;
  endfunction

  // Energy of one tick: the power code weighted by 2^shift.
  function automatic logic [ACC_W-1:0] scale_step(input logic [PWR_W-1:0] pw,
                                                  input logic [SHIFT_W-1:0] sh);
    logic [ACC_W-1:0] wide;
    wide = {{(ACC_W-PWR_W){1'b0}}, pw};
    return wide << sh;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= '0;
    else if (pwr_valid) hold_q <= pwr_code;
  end

  assign pwr_used = choose_power(pwr_valid, pwr_code, hold_q);
  assign step_inc = scale_step(pwr_used, step_shift);

endmodule

// File: rtl/eacc_accum.sv
module eacc_accum
  import eacc_pkg::*;
#(
  parameter int unsigned ACC_W = eacc_pkg::ACC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [ACC_W-1:0] step_inc,
  input  logic             clr_acc,
  input  logic             clr_roll,
  input  logic             snap_req,
  output logic [ACC_W-1:0] acc_q,
  output logic             carry_evt,
  output logic             roll_q,
  output logic [ACC_W-1:0] snap_e,
  output logic             snap_r
);

  acc_action_e      action;
  logic [ACC_W:0]   sum;

  function automatic logic [ACC_W:0] add_wide(input logic [ACC_W-1:0] a,
                                              input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign action    = pick_action(clr_acc, tick);
  assign sum       = add_wide(acc_q, step_inc);
  assign carry_evt = (action == ACT_ADD) && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      unique case (action)
        ACT_CLEAR: acc_q <= '0;
        ACT_ADD:   acc_q <= sum[ACC_W-1:0];
        default:   acc_q <= acc_q;
      endcase
    end
  end

  // A carry sets the flag even if a clear arrives in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)         roll_q <= 1'b0;
    else if (carry_evt) roll_q <= 1'b1;
    else if (clr_roll)  roll_q <= 1'b0;
  end

  // The snapshot takes the values as they stand before this cycle's update.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_e <= '0;
      snap_r <= 1'b0;
    end else if (snap_req) begin
      snap_e <= acc_q;
      snap_r <= roll_q;
    end
  end

endmodule

// File: rtl/energy_integrator.sv
module energy_integrator #(
  parameter int unsigned PWR_W      = eacc_pkg::PWR_W_DEF,
  parameter int unsigned ACC_W      = eacc_pkg::ACC_W_DEF,
  parameter int unsigned DIV_W      = eacc_pkg::DIV_W_DEF,
  parameter int unsigned SHIFT_W    = eacc_pkg::SHIFT_W_DEF,
  parameter int unsigned RST_RELOAD = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PWR_W-1:0]   pwr_code,
  input  logic               pwr_valid,
  input  logic [DIV_W-1:0]   reload_val,
  input  logic [SHIFT_W-1:0] step_shift,
  input  logic               clr_acc,
  input  logic               clr_roll,
  input  logic               snap_req,
  output logic [ACC_W-1:0]   snap_energy,
  output logic               snap_roll,
  output logic               roll_flag,
  output logic               tick_out
);

  // Internal events are named at this level for the bound checker.
  logic             tick;
  logic [PWR_W-1:0] pwr_used;
  logic [ACC_W-1:0] step_inc;
  logic [ACC_W-1:0] acc_now;
  logic             carry_evt;

  eacc_timebase #(
    .DIV_W      (DIV_W),
    .RST_RELOAD (RST_RELOAD)
  ) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload_in (reload_val),
    .tick      (tick)
  );

  eacc_sample_scale #(
    .PWR_W   (PWR_W),
    .ACC_W   (ACC_W),
    .SHIFT_W (SHIFT_W)
  ) u_scale (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_code   (pwr_code),
    .pwr_valid  (pwr_valid),
    .step_shift (step_shift),
    .pwr_used   (pwr_used),
    .step_inc   (step_inc)
  );

  eacc_accum #(
    .ACC_W (ACC_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .step_inc  (step_inc),
    .clr_acc   (clr_acc),
    .clr_roll  (clr_roll),
    .snap_req  (snap_req),
    .acc_q     (acc_now),
    .carry_evt (carry_evt),
    .roll_q    (roll_flag),
    .snap_e    (snap_energy),
    .snap_r    (snap_roll)
  );

  assign tick_out = tick;

endmodule

// File: rtl/eacc_checker.sv
module eacc_checker #(
  parameter int unsigned ACC_W = eacc_pkg::ACC_W_DEF,
  parameter int unsigned DIV_W = eacc_pkg::DIV_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_out,
  input logic [DIV_W-1:0] reload_val,
  input logic             clr_acc,
  input logic             clr_roll,
  input logic             snap_req,
  input logic [ACC_W-1:0] acc_now,
  input logic             carry_evt,
  input logic             roll_flag,
  input logic [ACC_W-1:0] snap_energy,
  input logic             snap_roll
);

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_out && reload_val != '0) |=> !tick_out);

  // R5
  carry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_evt |=> roll_flag);

  // R6
  roll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_flag && !clr_roll) |=> roll_flag);

  // R6
  roll_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(roll_flag) |-> $past(carry_evt));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> (acc_now == '0));

  // R7
  clear_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |-> !carry_evt);

  // R8
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_energy == $past(acc_now)) && (snap_roll == $past(roll_flag)));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(snap_energy) && $stable(snap_roll));

endmodule

bind energy_integrator eacc_checker #(
  .ACC_W (ACC_W),
  .DIV_W (DIV_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_out    (tick_out),
  .reload_val  (reload_val),
  .clr_acc     (clr_acc),
  .clr_roll    (clr_roll),
  .snap_req    (snap_req),
  .acc_now     (acc_now),
  .carry_evt   (carry_evt),
  .roll_flag   (roll_flag),
  .snap_energy (snap_energy),
  .snap_roll   (snap_roll)
);

// File: tb/energy_integrator_test.sv
module energy_integrator_test;

  localparam int PWR_W = 16;
  localparam int ACC_W = 32;
  localparam int DIV_W = 16;
  localparam int RSTR  = 3;
  localparam longint MODV = 64'd1 << ACC_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PWR_W-1:0] pwr_code = '0;
  logic             pwr_valid = 1'b0;
  logic [DIV_W-1:0] reload_val = 16'd3;
  logic [1:0]       step_shift = 2'd0;
  logic             clr_acc = 1'b0, clr_roll = 1'b0, snap_req = 1'b0;
  logic [ACC_W-1:0] snap_energy;
  logic             snap_roll, roll_flag, tick_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string tag  = "R9";

  // Behavioural reference state.
  longint m_acc, m_hold, m_cnt, m_snap;
  bit     m_roll, m_snapr;

  always #2.5 clk = ~clk;

  energy_integrator #(.RST_RELOAD(RSTR)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_code(pwr_code), .pwr_valid(pwr_valid),
    .reload_val(reload_val), .step_shift(step_shift), .clr_acc(clr_acc),
    .clr_roll(clr_roll), .snap_req(snap_req), .snap_energy(snap_energy),
    .snap_roll(snap_roll), .roll_flag(roll_flag), .tick_out(tick_out)
  );

  task automatic chk(input string t, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", t, act, exp);
    end
  endtask

  function automatic longint cur_power();
    return pwr_valid ? longint'(pwr_code) : m_hold;
  endfunction

  function automatic bit carry_next();
    return (m_cnt == 0) && !clr_acc &&
           ((m_acc + (cur_power() << step_shift)) >= MODV);
  endfunction

  task automatic compare_all();
    chk("R1 tick", longint'(tick_out), longint'(m_cnt == 0));
    chk({tag, " snap_energy"}, longint'(snap_energy), m_snap);
    chk({tag, " snap_roll"}, longint'(snap_roll), longint'(m_snapr));
    chk("R6 roll_flag", longint'(roll_flag), longint'(m_roll));
  endtask

  // Advance the reference with the inputs now driven, then sample after the edge.
  task automatic cyc();
    bit     tk;
    longint pw, s;
    bit     carry;
    tk = (m_cnt == 0);
    pw = cur_power();
    carry = 1'b0;
    if (pwr_valid) m_hold = longint'(pwr_code);
    if (tk) m_cnt = longint'(reload_val); else m_cnt = m_cnt - 1;
    if (snap_req) begin m_snap = m_acc; m_snapr = m_roll; end
    if (clr_acc) m_acc = 0;
    else if (tk) begin
      s = m_acc + (pw << step_shift);
      if (s >= MODV) carry = 1'b1;
      m_acc = s % MODV;
    end
    if (carry) m_roll = 1'b1; else if (clr_roll) m_roll = 1'b0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    pwr_valid = 1'b0; clr_acc = 1'b0; clr_roll = 1'b0; snap_req = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int guard;
    repeat (3) @(negedge clk);
    m_acc = 0; m_hold = 0; m_cnt = RSTR; m_snap = 0; m_roll = 0; m_snapr = 0;
    // R9: reset state at the ports
    chk("R9 reset snap_energy", longint'(snap_energy), 0);
    chk("R9 reset roll_flag", longint'(roll_flag), 0);
    chk("R9 reset snap_roll", longint'(snap_roll), 0);
    rst_n = 1'b1;
    // R9: first snapshot after reset shows zero, first tick after RST_RELOAD+1
    snap_req = 1'b1; cyc(); quiet();

    // R4: sparse valid strobes, held value reused on empty ticks
    tag = "R4";
    for (int i = 0; i < 60; i++) begin
      pwr_valid = (i % 5 == 0);
      pwr_code  = 16'(100 + 7 * i);
      snap_req  = (i % 7 == 3);
      cyc(); quiet();
    end

    // R2: reload changed mid-period, several values
    tag = "R2";
    for (int i = 0; i < 120; i++) begin
      if (i == 2)  reload_val = 16'd6;
      if (i == 45) reload_val = 16'd0;
      if (i == 61) reload_val = 16'd2;
      pwr_valid = (i % 3 == 1);
      pwr_code  = 16'(1000 + i);
      snap_req  = (i % 4 == 0);
      cyc(); quiet();
    end

    // R3: each step scale in turn, snapshots on and off tick cycles
    tag = "R3";
    for (int sh = 0; sh < 4; sh++) begin
      step_shift = 2'(sh);
      for (int i = 0; i < 30; i++) begin
        pwr_valid = 1'b1;
        pwr_code  = 16'(16'hF00D ^ (i * 37));
        snap_req  = (i % 4 == 2);
        cyc(); quiet();
      end
    end

    // R7: clear on a tick cycle, then clear off a tick
    tag = "R7";
    step_shift = 2'd1; reload_val = 16'd4;
    guard = 0;
    while (m_cnt != 0 && guard < 20) begin cyc(); guard++; end
    pwr_valid = 1'b1; pwr_code = 16'd5000; clr_acc = 1'b1;
    cyc(); quiet();
    snap_req = 1'b1; cyc(); quiet();
    chk("R7 clear beats tick", longint'(snap_energy), 0);
    for (int i = 0; i < 12; i++) begin pwr_valid = 1'b1; pwr_code = 16'd300; cyc(); quiet(); end
    clr_acc = 1'b1; cyc(); quiet();
    snap_req = 1'b1; cyc(); quiet();
    chk("R7 clear off tick", longint'(snap_energy), m_snap);

    // R5: drive to wrap at full rate; clear request coincides with the carry (R6)
    tag = "R5";
    reload_val = 16'd0; step_shift = 2'd3;
    guard = 0;
    pwr_code = 16'hFFFF; pwr_valid = 1'b1;
    while (!carry_next() && guard < 9000) begin
      cyc(); pwr_code = 16'hFFFF; pwr_valid = 1'b1; guard++;
    end
    clr_roll = 1'b1; snap_req = 1'b1;
    cyc(); quiet();
    chk("R6 carry beats clear", longint'(roll_flag), 1);
    chk("R5 wrapped value", longint'(m_acc < (longint'(16'hFFFF) << 3)), 1);
    snap_req = 1'b1; cyc(); quiet();
    chk("R8 snap sees flag", longint'(snap_roll), 1);
    for (int i = 0; i < 5; i++) cyc();
    chk("R6 sticky", longint'(roll_flag), 1);
    clr_roll = 1'b1; cyc(); quiet();
    chk("R6 cleared", longint'(roll_flag), 0);
    tag = "R8";
    for (int i = 0; i < 10; i++) cyc();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule